// File: doc/BRIEF.md
# Log-Depth Prefix Carry Adder

This block adds two unsigned N-bit operands and a one-bit carry-in. Each bit position is first classified by a carry status: it kills an incoming carry (both operand bits 0), generates a carry of its own (both bits 1), or propagates whatever carry arrives (bits differ). The carry-in is handled as one extra status below bit 0. It generates when the carry-in is 1 and kills when it is 0.

The statuses are merged by an associative operator. The operator keeps the upper status unless the upper status propagates; in that case it takes the lower one. The merging runs over a prefix network whose span doubles at each level, so every prefix from the carry-in up to each bit is ready after ceil(log2(N+1)) levels. A merged prefix that generates means the carry into the next bit is 1, and one that kills means it is 0. The sum bits are the operand XOR combined with those carries. The sum and the carry-out are registered once, with a synchronous active-high reset, so the adder can sit directly in a clocked datapath.

Top module: `cps_adder`

## Requirements
- R1: When `rst` is high at a rising clock edge, `sum` and `cout` are both 0 after that edge.
- R2: When `rst` is low at a rising edge, after that edge `sum` equals the low N bits of the unsigned value a + b + cin, using the inputs sampled at that edge.
- R3: `cout` equals bit N of the same (N+1)-bit value a + b + cin and appears on the same edge as the matching `sum`.
- R4: When every position propagates (a XOR b is all ones), the carry-in passes through the whole width: with cin = 1 the result is `sum` = 0 and `cout` = 1, and with cin = 0 it is `sum` all ones and `cout` = 0.
- R5: A position where both operand bits are 0 stops any carry from below: the bits above it receive no carry from the lower part.
- R6: The carry-in acts as a position below bit 0: with a = b = 0 and cin = 1 the result is `sum` = 1 and `cout` = 0, and with cin = 0 it is all zeros.
- R7: No merged prefix status, from the carry-in position up to any bit, is ever propagate.
- R8: R2 and R3 hold for any width N of at least 1. The width N = 8 is checked over every one of its 2^17 input combinations.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| a | input | N | First operand, unsigned |
| b | input | N | Second operand, unsigned |
| cin | input | 1 | Carry-in |
| sum | output | N | Registered sum, low N bits |
| cout | output | 1 | Registered carry-out, bit N of the result |

## Verification
The carry network is purely combinational, and only the output register lies between the operands and the ports. The `sum` and `cout` for an input vector are therefore both due exactly one rising edge after that vector is sampled. The bench changes the inputs on the falling edge and lets one rising edge capture them. It reads both outputs a short time after that edge, before the next falling edge brings new inputs, so every comparison sees the result of exactly one vector. The checker uses the same one-edge distance: it compares the outputs with the reference value taken from the inputs one cycle earlier.

// File: rtl/cps_pkg.sv
package cps_pkg;

  // Two-bit carry status: gen set = generate, prop set = propagate,
  // neither set = kill. Both set never arises.
  typedef struct packed {
    logic gen;
    logic prop;
  } cps_status_t;

  // Associative merge: upper span wins unless it propagates,
  // in which case the lower span decides.
  function automatic cps_status_t cps_merge(cps_status_t upper, cps_status_t lower);
    cps_status_t r;
    r.gen  = upper.gen | (upper.prop & lower.gen);
    r.prop = upper.prop & lower.prop;
    return r;
  endfunction

endpackage

// File: rtl/cps_status_gen.sv
module cps_status_gen #(
  parameter int N = 32
) (
  input  logic [N-1:0]                  a_i,
  input  logic [N-1:0]                  b_i,
  input  logic                          cin_i,
  output cps_pkg::cps_status_t [N:0]    stat_o,
  output logic [N-1:0]                  half_sum_o
);

  // Entry 0 is the carry-in position; entry i+1 is operand bit i.
  assign stat_o[0].gen  = cin_i;
  assign stat_o[0].prop = 1'b0;

  for (genvar i = 0; i < N; i++) begin : g_bit
    assign stat_o[i+1].gen  = a_i[i] & b_i[i];
    assign stat_o[i+1].prop = a_i[i] ^ b_i[i];
    assign half_sum_o[i]    = a_i[i] ^ b_i[i];
  end

endmodule

// File: rtl/cps_prefix_tree.sv
module cps_prefix_tree #(
  parameter int M = 33
) (
  input  cps_pkg::cps_status_t [M-1:0] stat_i,
  output logic [M-1:0]                 carry_o,
  output logic                         open_prefix_o
);

  localparam int LEVELS = (M > 1) ? $clog2(M) : 1;

  cps_pkg::cps_status_t [M-1:0] lvl [LEVELS+1];
  logic [M-1:0] prop_final;

  assign lvl[0] = stat_i;

  for (genvar l = 0; l < LEVELS; l++) begin : g_level
    localparam int SPAN = 1 << l;
    for (genvar k = 0; k < M; k++) begin : g_node
      if (k >= SPAN) begin : g_merge
        assign lvl[l+1][k] = cps_pkg::cps_merge(lvl[l][k], lvl[l][k-SPAN]);
      end else begin : g_pass
        assign lvl[l+1][k] = lvl[l][k];
      end
    end
  end

  for (genvar k = 0; k < M; k++) begin : g_out
    assign carry_o[k]    = lvl[LEVELS][k].gen;
    assign prop_final[k] = lvl[LEVELS][k].prop;
  end

  assign open_prefix_o = |prop_final;

endmodule

// File: rtl/cps_sum_reg.sv
module cps_sum_reg #(
  parameter int N = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [N-1:0]  half_sum_i,
  input  logic [N:0]    carry_i,
  output logic [N-1:0]  sum_o,
  output logic          cout_o
);

  logic [N-1:0] sum_c;

  assign sum_c = half_sum_i ^ carry_i[N-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      sum_o  <= '0;
      cout_o <= 1'b0;
    end else begin
      sum_o  <= sum_c;
      cout_o <= carry_i[N];
    end
  end

endmodule

// File: rtl/cps_adder.sv
module cps_adder #(
  parameter int N = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [N-1:0]  a,
  input  logic [N-1:0]  b,
  input  logic          cin,
  output logic [N-1:0]  sum,
  output logic          cout
);

  localparam int M = N + 1;

  cps_pkg::cps_status_t [N:0] stat;
  logic [N-1:0]               half_sum;
  logic [N:0]                 carry;
  logic                       open_prefix;

  cps_status_gen #(.N(N)) status_i (
    .a_i        (a),
    .b_i        (b),
    .cin_i      (cin),
    .stat_o     (stat),
    .half_sum_o (half_sum)
  );

  cps_prefix_tree #(.M(M)) tree_i (
    .stat_i        (stat),
    .carry_o       (carry),
    .open_prefix_o (open_prefix)
  );

  cps_sum_reg #(.N(N)) out_i (
    .clk        (clk),
    .rst        (rst),
    .half_sum_i (half_sum),
    .carry_i    (carry),
    .sum_o      (sum),
    .cout_o     (cout)
  );

endmodule

// File: rtl/cps_adder_chk.sv
module cps_adder_chk #(
  parameter int N = 32
) (
  input logic          clk,
  input logic          rst,
  input logic [N-1:0]  a,
  input logic [N-1:0]  b,
  input logic          cin,
  input logic [N-1:0]  sum,
  input logic          cout,
  input logic          open_prefix
);

  logic [N:0] ref_w;
  assign ref_w = {1'b0, a} + {1'b0, b} + {{N{1'b0}}, cin};

  assert_reset_clears_R1: assert property (@(posedge clk)
    rst |=> (sum == '0) && !cout);

  assert_sum_matches_R2: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> sum == $past(ref_w[N-1:0]));

  assert_cout_matches_R3: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> cout == $past(ref_w[N]));

  assert_full_propagate_R4: assert property (@(posedge clk) disable iff (rst)
    ((a ^ b) == {N{1'b1}}) |=> (cout == $past(cin)) && (sum == {N{!$past(cin)}}));

  assert_no_open_prefix_R7: assert property (@(posedge clk) disable iff (rst)
    !open_prefix);

endmodule

bind cps_adder cps_adder_chk #(.N(N)) chk_i (
  .clk         (clk),
  .rst         (rst),
  .a           (a),
  .b           (b),
  .cin         (cin),
  .sum         (sum),
  .cout        (cout),
  .open_prefix (open_prefix)
);

// File: tb/cps_adder_tb_top.sv
module cps_adder_tb_top;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2 clk = ~clk;

  logic [31:0] a32 = '0, b32 = '0;
  logic        c32 = 1'b0;
  logic [31:0] s32;
  logic        o32;

  logic [7:0]  a8 = '0, b8 = '0;
  logic        c8 = 1'b0;
  logic [7:0]  s8;
  logic        o8;

  cps_adder #(.N(32)) dut_i (
    .clk(clk), .rst(rst), .a(a32), .b(b32), .cin(c32), .sum(s32), .cout(o32)
  );

  cps_adder #(.N(8)) dut8_i (
    .clk(clk), .rst(rst), .a(a8), .b(b8), .cin(c8), .sum(s8), .cout(o8)
  );

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  function automatic logic [32:0] model32(logic [31:0] x, logic [31:0] y, logic c);
    return {1'b0, x} + {1'b0, y} + {32'd0, c};
  endfunction

  function automatic logic [8:0] model8(logic [7:0] x, logic [7:0] y, logic c);
    return {1'b0, x} + {1'b0, y} + {8'd0, c};
  endfunction

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Drive on falling edge, let one rising edge register, sample 1 ns later.
  task automatic apply32(string req, logic [31:0] x, logic [31:0] y, logic c);
    logic [32:0] e;
    @(negedge clk);
    a32 = x; b32 = y; c32 = c;
    e = model32(x, y, c);
    @(posedge clk); #1;
    check({req, " sum"},  {32'd0, s32}, {32'd0, e[31:0]});
    check({req, " cout"}, {63'd0, o32}, {63'd0, e[32]});
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    #1;
    check("R1 sum32 reset",  {32'd0, s32}, 64'd0);
    check("R1 cout32 reset", {63'd0, o32}, 64'd0);
    check("R1 sum8 reset",   {56'd0, s8},  64'd0);
    @(negedge clk);
    rst = 1'b0;

    apply32("R6 cin only",        32'h0, 32'h0, 1'b1);
    apply32("R6 all zero",        32'h0, 32'h0, 1'b0);
    apply32("R4 R7 prop cin1",    32'hFFFF_FFFF, 32'h0, 1'b1);
    apply32("R4 R7 prop cin0",    32'hFFFF_FFFF, 32'h0, 1'b0);
    apply32("R4 R7 alt prop",     32'hAAAA_AAAA, 32'h5555_5555, 1'b1);
    apply32("R3 all generate",    32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b1);
    apply32("R3 top carry",       32'h8000_0000, 32'h8000_0000, 1'b0);
    apply32("R2 mid carry",       32'h7FFF_FFFF, 32'h0000_0001, 1'b0);
    apply32("R5 kill at bit16",   32'h0000_FFFF, 32'h0000_FFFF, 1'b1);
    apply32("R5 kill stops prop", 32'hFFFE_FFFF, 32'h0000_0000, 1'b1);

    // Reset with live inputs clears outputs.
    @(negedge clk);
    rst = 1'b1; a32 = 32'hFFFF_FFFF; b32 = 32'h1; c32 = 1'b1;
    @(posedge clk); #1;
    check("R1 mid reset sum",  {32'd0, s32}, 64'd0);
    check("R1 mid reset cout", {63'd0, o32}, 64'd0);
    @(negedge clk);
    rst = 1'b0;

    // Exhaustive 8-bit sweep (R8) with random 32-bit vectors (R2, R3).
    for (int v = 0; v < (1 << 17); v++) begin
      logic [8:0]  e8;
      logic [32:0] e32;
      logic [31:0] rx, ry;
      logic        rc;
      @(negedge clk);
      a8 = v[7:0]; b8 = v[15:8]; c8 = v[16];
      rx = $urandom(); ry = $urandom(); rc = 1'($urandom());
      if (v % 64 == 5) ry = ~rx;
      a32 = rx; b32 = ry; c32 = rc;
      e8  = model8(v[7:0], v[15:8], v[16]);
      e32 = model32(rx, ry, rc);
      @(posedge clk); #1;
      check("R8 sum8",    {56'd0, s8},  {56'd0, e8[7:0]});
      check("R8 cout8",   {63'd0, o8},  {63'd0, e8[8]});
      check("R2 sum32",   {32'd0, s32}, {32'd0, e32[31:0]});
      check("R3 cout32",  {63'd0, o32}, {63'd0, e32[32]});
    end

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule